// File: doc/BRIEF.md
# Stereo Soft-Mute Ramp with Silence Detector

This block sits in a stereo audio sample path and scales both channels by a common gain that moves in 1 dB steps, one step per sample strobe. Pulling the play enable low walks the gain from unity down to exactly zero over 104 samples; raising it walks the gain back up along the same curve. A request that reverses mid-way turns the walk around at the current step. Samples leave one clock after they arrive, with a matching strobe.

In parallel the block counts consecutive frames in which both channels are zero. After 1024 such frames it raises an analog-mute request, which drops again on the first frame carrying any nonzero sample. A clock-fault input forces the digital ramp downward, replaying the last sample taken before the fault, and the analog-mute request follows only once the ramp has reached zero. An undervoltage input raises the analog-mute request at once, whatever the digital gain.

Top module: `soft_mute_unit`

## Requirements
- R1: After reset both output samples are zero, the output strobe is low, the gain sits at unity (step 0), the mute-done flag is low and the analog-mute request is low while the undervoltage input is low.
- R2: On each cycle with the input strobe high, each output sample one cycle later equals the selected input sample times the current gain (unsigned, 23 fraction bits), rounded to nearest with halves going toward positive infinity, then clamped to the signed sample range; the output strobe follows the input strobe by one cycle. At step 0 the output equals the input exactly.
- R3: While the play enable is low, each strobe moves the step index up by one; the gain at step k is round((gain at k-1) x 7476355 / 2^23), starting from 2^23 at step 0.
- R4: At step 104 the gain is exactly zero, the mute-done flag is high, and further mute strobes keep the step at 104.
- R5: While the play enable is high, each strobe moves the step index down by one, reaching exactly unity at step 0 and staying there.
- R6: A change of the play enable during a ramp reverses the ramp from the current step without jumping to either end.
- R7: The analog-mute request goes high after 1024 consecutive strobes in which both input samples are zero; the first strobe with any nonzero sample clears the count and drops the request.
- R8: While the clock-fault input is high the ramp moves down regardless of the play enable, the scaled sample is the last one taken before the fault, and the analog-mute request stays low until the step reaches 104 (unless R7 or R9 applies).
- R9: The undervoltage input raises the analog-mute request in the same cycle, independent of gain and sample data.
- R10: Cycles without an input strobe leave the step index, the outputs and the silence count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Sample strobe, one cycle per stereo frame |
| in_left | input | DW | Left input sample, two's complement |
| in_right | input | DW | Right input sample, two's complement |
| play_en | input | 1 | High: ramp toward unity; low: ramp toward zero |
| clk_fault | input | 1 | Clock-error or power-failure indication |
| uv_req | input | 1 | Undervoltage request, forces analog mute |
| out_vld | output | 1 | Output sample strobe |
| out_left | output | DW | Scaled left sample |
| out_right | output | DW | Scaled right sample |
| mute_done | output | 1 | Gain has reached exactly zero |
| amute | output | 1 | Analog-mute request |

## Verification
A wrong step index shows on the very next strobe as an output sample scaled by a neighbouring gain, roughly 11 percent off, so a comparison of every frame against an independent gain curve exposes it within one frame. A broken saturation of the step at either end shows as mute-done dropping or a nonzero output under full mute on the following strobe. A silence count that starts early or fails to clear shows as the analog-mute request changing one frame away from the 1024th zero frame or staying high after a nonzero one; the clock-fault path shows as the request rising before mute-done or as output that tracks the live input instead of the held sample.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_t;
endpackage

// File: rtl/gain_ramp.sv
module gain_ramp
  import smr_pkg::*;
#(
  parameter int STEPS = 104,
  parameter int GW    = 24,
  parameter int COEF  = 7476355,
  localparam int IW   = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          go_down,
  output logic [IW-1:0] idx,
  output logic [GW-1:0] gain,
  output logic          at_floor
);
  // gain for step k: repeated multiply by the step coefficient, zero at the end
  function automatic logic [GW-1:0] gain_at(input int k);
    longint g;
    g = longint'(1) << (GW - 1);
    for (int i = 0; i < STEPS; i++)
      if (i < k) g = (g * longint'(COEF) + (longint'(1) << (GW - 2))) >>> (GW - 1);
    if (k >= STEPS) g = 0;
    return GW'(g);
  endfunction

  logic [GW-1:0] gtab [STEPS+1];
  for (genvar s = 0; s <= STEPS; s++) begin : g_tab
    assign gtab[s] = gain_at(s);
  end

  ramp_dir_t dir;
  always_comb begin
    if (!step_en)     dir = RAMP_HOLD;
    else if (go_down) dir = RAMP_DOWN;
    else              dir = RAMP_UP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else begin
      case (dir)
        RAMP_DOWN: if (idx != IW'(STEPS)) idx <= idx + 1'b1;
        RAMP_UP:   if (idx != '0)         idx <= idx - 1'b1;
        default:   idx <= idx;
      endcase
    end
  end

  assign gain     = gtab[idx];
  assign at_floor = (idx == IW'(STEPS));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && go_down && !at_floor |=> idx == $past(idx) + 1'b1);
  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !go_down && idx != '0 |=> idx == $past(idx) - 1'b1);
  // R4
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && go_down && at_floor |=> at_floor);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(idx));
endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
  parameter int ZFRAMES = 1024,
  localparam int CW     = $clog2(ZFRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic is_zero,
  output logic zero_hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (step_en) begin
      if (!is_zero)                     cnt <= '0;
      else if (cnt != CW'(ZFRAMES))     cnt <= cnt + 1'b1;
    end
  end

  assign zero_hit = (cnt == CW'(ZFRAMES));

  // R7
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !is_zero |=> !zero_hit);
  // R7
  zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_hit) |-> $past(step_en && is_zero));
endmodule

// File: rtl/sample_scale.sv
module sample_scale #(
  parameter int DW = 24,
  parameter int GW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] dout
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (GW - 2);
  localparam logic signed [PW-1:0] MAXV = PW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  // multiply, round half up, clamp to the sample range
  function automatic logic signed [DW-1:0] scale_round(
      input logic signed [DW-1:0] s, input logic [GW-1:0] g);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] r;
    p = $signed({{(GW+1){s[DW-1]}}, s}) * $signed({{(DW+1){1'b0}}, g});
    r = (p + HALF) >>> (GW - 1);
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  dout <= '0;
    else if (en) dout <= scale_round(din, gain);
  end

  // R2
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && gain == (GW'(1) << (GW - 1)) |=> dout == $past(din));
  // R10
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
endmodule

// File: rtl/soft_mute_unit.sv
module soft_mute_unit #(
  parameter int DW      = 24,
  parameter int GW      = 24,
  parameter int STEPS   = 104,
  parameter int ZFRAMES = 1024,
  parameter int COEF    = 7476355
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic                 play_en,
  input  logic                 clk_fault,
  input  logic                 uv_req,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 mute_done,
  output logic                 amute
);
  localparam int NCH = 2;
  localparam int IW  = $clog2(STEPS + 1);

  logic signed [DW-1:0] live [NCH];
  logic signed [DW-1:0] held [NCH];
  logic signed [DW-1:0] src  [NCH];
  logic signed [DW-1:0] scl  [NCH];
  logic [GW-1:0]        gain;
  logic [IW-1:0]        step_idx;
  logic                 go_down;
  logic                 at_floor;
  logic                 zero_hit;
  logic                 both_zero;

  assign live[0]   = in_left;
  assign live[1]   = in_right;
  assign go_down   = clk_fault | ~play_en;
  assign both_zero = (in_left == '0) && (in_right == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                     held[c] <= '0;
      else if (in_vld && !clk_fault)  held[c] <= live[c];
    end
    assign src[c] = clk_fault ? held[c] : live[c];

    sample_scale #(.DW(DW), .GW(GW)) u_scale (
      .clk(clk), .rst_n(rst_n), .en(in_vld),
      .din(src[c]), .gain(gain), .dout(scl[c])
    );
  end

  gain_ramp #(.STEPS(STEPS), .GW(GW), .COEF(COEF)) u_ramp (
    .clk(clk), .rst_n(rst_n), .step_en(in_vld), .go_down(go_down),
    .idx(step_idx), .gain(gain), .at_floor(at_floor)
  );

  zero_watch #(.ZFRAMES(ZFRAMES)) u_zero (
    .clk(clk), .rst_n(rst_n), .step_en(in_vld),
    .is_zero(both_zero), .zero_hit(zero_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  assign out_left  = scl[0];
  assign out_right = scl[1];
  assign mute_done = at_floor;
  assign amute     = uv_req | zero_hit | (clk_fault & at_floor);

  // R9
  uv_amute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_req |-> amute);
  // R8
  fault_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fault && !at_floor && !uv_req && !zero_hit |-> !amute);
  // R4
  floor_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && at_floor |=> out_left == '0 && out_right == '0);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
endmodule

// File: tb/soft_mute_unit_test.sv
module soft_mute_unit_test;
  localparam int DW = 24;
  localparam int NSTEP = 104;
  localparam int NZ = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] in_left = '0;
  logic signed [DW-1:0] in_right = '0;
  logic play_en = 1'b1;
  logic clk_fault = 1'b0;
  logic uv_req = 1'b0;
  logic out_vld;
  logic signed [DW-1:0] out_left, out_right;
  logic mute_done, amute;

  soft_mute_unit uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_left(in_left),
    .in_right(in_right), .play_en(play_en), .clk_fault(clk_fault),
    .uv_req(uv_req), .out_vld(out_vld), .out_left(out_left),
    .out_right(out_right), .mute_done(mute_done), .amute(amute)
  );

  always #4 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  string tag = "R2";

  longint gt [NSTEP+1];
  int mk = 0, zc = 0;
  longint hold_l = 0, hold_r = 0, exp_l = 0, exp_r = 0;
  bit exp_v = 0;

  function automatic longint ref_scale(longint s, longint g);
    longint q;
    longint r;
    q = s * g + 64'sd4194304;
    if (q >= 0) r = q / 64'sd8388608;
    else        r = -((-q + 64'sd8388607) / 64'sd8388608);
    if (r > 64'sd8388607)  r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r;
  endfunction

  task automatic chk(string t, bit ok, longint act, longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, expv, $time);
    end
  endtask

  initial begin
    gt[0] = 64'sd8388608;
    for (int k = 1; k < NSTEP; k++) gt[k] = (gt[k-1] * 64'sd7476355 + 64'sd4194304) >>> 23;
    gt[NSTEP] = 0;
  end

  // reference model, one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mk <= 0; zc <= 0; hold_l <= 0; hold_r <= 0; exp_l <= 0; exp_r <= 0; exp_v <= 0;
    end else begin
      exp_v <= in_vld;
      if (in_vld) begin
        exp_l <= ref_scale(clk_fault ? hold_l : longint'(in_left), gt[mk]);
        exp_r <= ref_scale(clk_fault ? hold_r : longint'(in_right), gt[mk]);
        if (!clk_fault) begin hold_l <= in_left; hold_r <= in_right; end
        if (clk_fault || !play_en) mk <= (mk < NSTEP) ? mk + 1 : mk;
        else                       mk <= (mk > 0) ? mk - 1 : 0;
        zc <= (in_left == 0 && in_right == 0) ? ((zc < NZ) ? zc + 1 : zc) : 0;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ea;
      ea = uv_req || (zc >= NZ) || (clk_fault && mk == NSTEP);
      chk({tag, " left"}, longint'(out_left) == exp_l, out_left, exp_l);
      chk({tag, " right"}, longint'(out_right) == exp_r, out_right, exp_r);
      chk("R2 strobe", out_vld == exp_v, out_vld, exp_v);
      chk("R4 mute_done", mute_done == (mk == NSTEP), mute_done, mk == NSTEP);
      chk("R7 amute", amute == ea, amute, ea);
    end
  end

  task automatic frame(int l, int r);
    @(posedge clk); #2;
    in_vld = 1'b1; in_left = DW'(l); in_right = DW'(r);
    @(posedge clk); #2;
    in_vld = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 out_left", out_left == 0, out_left, 0);
    chk("R1 out_vld", out_vld == 0, out_vld, 0);
    chk("R1 mute_done", mute_done == 0, mute_done, 0);
    chk("R1 amute", amute == 0, amute, 0);

    // R2 unity pass of varied data
    tag = "R2";
    for (int i = 0; i < 20; i++) frame(i * 400001 - 4000000, 8388607 - i * 777);
    chk("R2 unity exact", out_left == DW'(19 * 400001 - 4000000), out_left, 19 * 400001 - 4000000);

    // R3 ramp down then R6 reversal
    tag = "R3";
    play_en = 1'b0;
    for (int i = 0; i < 30; i++) frame(-8388608 + i, 8388607 - i);
    tag = "R6";
    play_en = 1'b1;
    for (int i = 0; i < 10; i++) frame(3000000, -3000000);
    frame(1000000, -1000000);
    chk("R6 turnaround step", longint'(out_left) == ref_scale(1000000, gt[20]),
        out_left, ref_scale(1000000, gt[20]));
    chk("R6 not muted", mute_done == 0, mute_done, 0);

    // R4 reach full mute
    tag = "R4";
    play_en = 1'b0;
    for (int i = 0; i < 110; i++) frame(8388607, -8388608);
    chk("R4 zero out", out_left == 0 && out_right == 0, out_left, 0);
    chk("R4 done", mute_done == 1, mute_done, 1);

    // R5 ramp back up
    tag = "R5";
    play_en = 1'b1;
    for (int i = 0; i < 110; i++) frame(5000000 - i * 9000, -5000000 + i * 3);
    frame(-7654321, 1234567);
    chk("R5 unity again", out_left == -DW'(7654321), out_left, -7654321);

    // R10 no strobe, inputs move
    tag = "R10";
    @(posedge clk); #2; in_left = 24'sd55; in_right = -24'sd55;
    repeat (5) @(posedge clk);
    #2 chk("R10 hold", out_left == -DW'(7654321), out_left, -7654321);

    // R7 silence detection
    tag = "R7";
    for (int i = 0; i < NZ - 1; i++) frame(0, 0);
    chk("R7 not yet", amute == 0, amute, 0);
    frame(0, 0);
    chk("R7 raised", amute == 1, amute, 1);
    frame(0, 0);
    frame(0, 1);
    chk("R7 released", amute == 0, amute, 0);

    // R9 undervoltage immediate
    tag = "R9";
    @(posedge clk); #2 uv_req = 1'b1;
    #1 chk("R9 immediate", amute == 1, amute, 1);
    frame(100, 100);
    @(posedge clk); #2 uv_req = 1'b0;

    // R8 fault: ramp down on held sample, analog mute after
    tag = "R8";
    frame(2222222, -3333333);
    clk_fault = 1'b1;
    for (int i = 0; i < 50; i++) frame(17, -17);
    chk("R8 amute late", amute == 0, amute, 0);
    for (int i = 0; i < 60; i++) frame(17, -17);
    chk("R8 amute after ramp", amute == 1, amute, 1);
    clk_fault = 1'b0;
    for (int i = 0; i < 110; i++) frame(17 + i, -17 - i);
    chk("R8 recovered", amute == 0, amute, 0);

    repeat (3) @(posedge clk);
    #2 finish_run();
  end
endmodule